// File: doc/BRIEF.md
# GPIO Wake-Up Event Detector

This block monitors a small group of general-purpose input pins (three by default) and turns a chosen transition on any of them into a wake request. Each pin first passes through a two-flop synchronizer. An edge detector then looks for a rising or a falling transition, and the direction is chosen separately for each pin. A detected transition sets that pin's sticky status bit. The bit stays set until the host clears it by writing a one to it.

There are two active-low wake outputs, and each pin has its own enable toward each of them. A wake output is held low for as long as any pin has its status bit set and its enable for that output asserted. A pin can therefore drive one wake line, both, or neither. The host sees four small registers behind a single address bus: edge polarity, routing toward wake line A, routing toward wake line B, and status. A write strobe updates a register, and the read data follows the address combinationally.

Top module: `gpio_wake_detector`

## Requirements
- R1: After reset the polarity, both routing registers and the status register read 0, and both wake outputs are high.
- R2: With polarity bit i = 0, a low-to-high transition on pin i sets status bit i. A high-to-low transition on that pin leaves it unchanged.
- R3: With polarity bit i = 1, a high-to-low transition on pin i sets status bit i. A low-to-high transition on that pin leaves it unchanged.
- R4: A pin change that is present at clock edge n becomes visible in the status register after edge n+2, which is the third edge that sees it. It is not visible earlier.
- R5: A status bit stays set until a write to address 3 carries a 1 in that bit. Writing 0 to a bit leaves it unchanged.
- R6: When a qualifying edge and a clear of the same bit occur at the same clock edge, the bit ends up set.
- R7: wake_a_n is low exactly when some bit i has both status and routing-A (address 1, bit i) set.
- R8: wake_b_n is low exactly when some bit i has both status and routing-B (address 2, bit i) set. It does not depend on routing-A.
- R9: Register map, with bit i belonging to pin i: address 0 is polarity, 1 is routing A, 2 is routing B, 3 is status. A write changes only the addressed register. A write to status never sets a bit.
- R10: Pin levels present when reset is released produce no event. No status bit sets during the first three clock edges after reset.
- R11: A transition on one pin sets only that pin's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous wake-capable pin levels |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register address (write and read) |
| host_wdata | input | NUM_PINS | Write data |
| host_rdata | output | NUM_PINS | Read data for host_addr, combinational |
| wake_a_n | output | 1 | Active-low wake line A |
| wake_b_n | output | 1 | Active-low wake line B |

## Verification
Register writes take effect at the edge that samples the strobe, and read data and wake lines follow combinationally. The bench therefore compares them at the falling edge after that edge. A pin change reaches status and the wake lines only after the third rising edge that samples it, so the latency test reads status after the first, second and third edges and expects 0, 0 and 1. The bench's reference model keeps the pin levels of the last three edges. It recomputes the expected state at every rising edge, using the polarity that was in force before that edge.

// File: rtl/gwk_pkg.sv
package gwk_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_POL = 2'd0,
        REG_RTA = 2'd1,
        REG_RTB = 2'd2,
        REG_STS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } host_cmd_t;

    // Transition test for one pin: falling = 1 selects high-to-low.
    function automatic logic edge_hit(input logic cur, input logic prev, input logic falling);
        return falling ? (prev & ~cur) : (~prev & cur);
    endfunction

endpackage

// File: rtl/gwk_sync.sv
module gwk_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gwk_edge.sv
module gwk_edge
    import gwk_pkg::*;
#(
    parameter int W   = 3,
    parameter int ARM = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    localparam int CW = $clog2(ARM + 1);

    logic [CW-1:0] arm_cnt;
    logic          armed;
    logic [W-1:0]  prev_q;

    assign armed = (arm_cnt == CW'(ARM));

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_cnt <= '0;
            prev_q  <= '0;
        end else begin
            prev_q <= lvl;
            if (!armed) arm_cnt <= arm_cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = armed & edge_hit(lvl[i], prev_q[i], pol[i]);
    end
endmodule

// File: rtl/gwk_regs.sv
module gwk_regs
    import gwk_pkg::*;
#(
    parameter int W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [W-1:0]      host_wdata,
    input  logic [W-1:0]      hit,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      rta_q,
    output logic [W-1:0]      rtb_q,
    output logic [W-1:0]      sts_q,
    output logic [W-1:0]      host_rdata
);
    host_cmd_t    cmd;
    logic [W-1:0] clr_mask;

    assign cmd      = '{wr: host_wr, sel: reg_sel_e'(host_addr)};
    assign clr_mask = (cmd.wr && cmd.sel == REG_STS) ? host_wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= '0;
            rta_q <= '0;
            rtb_q <= '0;
            sts_q <= '0;
        end else begin
            if (cmd.wr && cmd.sel == REG_POL) pol_q <= host_wdata;
            if (cmd.wr && cmd.sel == REG_RTA) rta_q <= host_wdata;
            if (cmd.wr && cmd.sel == REG_RTB) rtb_q <= host_wdata;
            sts_q <= (sts_q & ~clr_mask) | hit;
        end
    end

    always_comb begin
        unique case (cmd.sel)
            REG_POL: host_rdata = pol_q;
            REG_RTA: host_rdata = rta_q;
            REG_RTB: host_rdata = rtb_q;
            default: host_rdata = sts_q;
        endcase
    end
endmodule

// File: rtl/gpio_wake_detector.sv
module gpio_wake_detector
    import gwk_pkg::*;
#(
    parameter int NUM_PINS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [NUM_PINS-1:0] host_wdata,
    output logic [NUM_PINS-1:0] host_rdata,
    output logic                wake_a_n,
    output logic                wake_b_n
);
    localparam int NUM_WAKE = 2;
    localparam int ARM      = SYNC_STAGES + 1;

    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] pol_q, rta_q, rtb_q, sts_q;
    logic [NUM_PINS-1:0] route_en [NUM_WAKE];
    logic [NUM_WAKE-1:0] wake_n;

    gwk_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    gwk_edge #(.W(NUM_PINS), .ARM(ARM)) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (lvl),
        .pol (pol_q),
        .hit (hit)
    );

    gwk_regs #(.W(NUM_PINS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .hit        (hit),
        .pol_q      (pol_q),
        .rta_q      (rta_q),
        .rtb_q      (rtb_q),
        .sts_q      (sts_q),
        .host_rdata (host_rdata)
    );

    assign route_en[0] = rta_q;
    assign route_en[1] = rtb_q;

    for (genvar w = 0; w < NUM_WAKE; w++) begin : g_wake
        assign wake_n[w] = ~|(sts_q & route_en[w]);
    end

    assign wake_a_n = wake_n[0];
    assign wake_b_n = wake_n[1];
endmodule

// File: rtl/gwk_checker.sv
module gwk_checker #(
    parameter int W   = 3,
    parameter int ARM = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         host_wr,
    input logic [1:0]   host_addr,
    input logic [W-1:0] hit,
    input logic [W-1:0] sts,
    input logic [W-1:0] pol,
    input logic [W-1:0] rta,
    input logic [W-1:0] rtb,
    input logic         wake_a_n,
    input logic         wake_b_n
);
    localparam int CW = $clog2(ARM + 1);
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != CW'(ARM)) since_rst <= since_rst + 1'b1;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (sts == '0 && pol == '0 && rta == '0 && rtb == '0 && wake_a_n && wake_b_n)); // R1

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_addr == 2'd3) |=> ((sts & $past(sts)) == $past(sts))); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((sts & $past(hit)) == $past(hit))); // R6

    AST_WAKE_A_UNROUTED: assert property (@(posedge clk) disable iff (rst)
        (rta == '0) |-> wake_a_n); // R7

    AST_WAKE_B_UNROUTED: assert property (@(posedge clk) disable iff (rst)
        (rtb == '0) |-> wake_b_n); // R8

    AST_CLEAR_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd3 && hit == '0) |=> ((sts & ~$past(sts)) == '0)); // R9

    AST_NO_EARLY_HIT: assert property (@(posedge clk) disable iff (rst)
        (since_rst != CW'(ARM)) |-> (hit == '0)); // R10
endmodule

bind gpio_wake_detector gwk_checker #(.W(NUM_PINS), .ARM(SYNC_STAGES + 1)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .hit      (hit),
    .sts      (sts_q),
    .pol      (pol_q),
    .rta      (rta_q),
    .rtb      (rtb_q),
    .wake_a_n (wake_a_n),
    .wake_b_n (wake_b_n)
);

// File: tb/gpio_wake_detector_test.sv
`timescale 1ns/1ps
module gpio_wake_detector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pin_in = '0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = '0;
    logic [2:0] host_wdata = '0;
    logic [2:0] host_rdata;
    logic       wake_a_n, wake_b_n;

    int nchecks = 0;
    int nerr = 0;

    // reference model state
    logic [2:0] m_pol = '0, m_rta = '0, m_rtb = '0, m_sts = '0;
    logic [2:0] h1 = '0, h2 = '0, h3 = '0;
    int         m_edges = 0;
    logic [2:0] cur_p = '0;

    always #5 clk = ~clk;

    gpio_wake_detector uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .wake_a_n(wake_a_n), .wake_b_n(wake_b_n)
    );

    function automatic logic exp_edge(input logic cur, input logic prev, input logic falling);
        return falling ? (prev && !cur) : (!prev && cur);
    endfunction

    function automatic logic [2:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_pol;
            2'd1: return m_rta;
            2'd2: return m_rtb;
            default: return m_sts;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [2:0] p, input logic wr, input logic [1:0] a, input logic [2:0] d);
        logic [2:0] hit_m;
        logic [2:0] clr;
        pin_in = p; host_wr = wr; host_addr = a; host_wdata = d;
        cur_p = p;
        @(posedge clk);
        hit_m = '0;
        if (rst) begin
            m_pol = '0; m_rta = '0; m_rtb = '0; m_sts = '0; m_edges = 0;
        end else begin
            if (m_edges < 4) m_edges++;
            if (m_edges >= 4)
                for (int i = 0; i < 3; i++) hit_m[i] = exp_edge(h2[i], h3[i], m_pol[i]);
            clr = (wr && a == 2'd3) ? d : 3'b000;
            m_sts = (m_sts & ~clr) | hit_m;
            if (wr && a == 2'd0) m_pol = d;
            if (wr && a == 2'd1) m_rta = d;
            if (wr && a == 2'd2) m_rtb = d;
        end
        h3 = h2; h2 = h1; h1 = p;
        @(negedge clk);
        check("R7 wake_a_n", 32'(wake_a_n), 32'(~|(m_sts & m_rta)));
        check("R8 wake_b_n", 32'(wake_b_n), 32'(~|(m_sts & m_rtb)));
        check("R9 rdata", 32'(host_rdata), 32'(exp_read(a)));
    endtask

    task automatic read_reg(input logic [1:0] a, input logic [2:0] exp, input string tag);
        step(cur_p, 1'b0, a, 3'b000);
        check(tag, 32'(host_rdata), 32'(exp));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        @(negedge clk);
        // R10: pins high through reset
        rst = 1'b1;
        repeat (3) step(3'b101, 1'b0, 2'd0, 3'b000);
        rst = 1'b0;
        // R1 reset state
        check("R1 wake_a_n", 32'(wake_a_n), 32'd1);
        check("R1 wake_b_n", 32'(wake_b_n), 32'd1);
        read_reg(2'd0, 3'b000, "R1 pol");
        read_reg(2'd1, 3'b000, "R1 route A");
        read_reg(2'd2, 3'b000, "R1 route B");
        read_reg(2'd3, 3'b000, "R1 status");
        repeat (4) read_reg(2'd3, 3'b000, "R10 status after reset release");
        step(3'b000, 1'b0, 2'd3, 3'b000);
        repeat (4) step(3'b000, 1'b0, 2'd3, 3'b000);
        step(3'b000, 1'b1, 2'd3, 3'b111);

        // R2 + R4: rising on pin 0, polarity 0
        step(3'b000, 1'b1, 2'd1, 3'b111);
        step(3'b001, 1'b0, 2'd3, 3'b000);
        check("R4 edge1", 32'(host_rdata), 32'd0);
        step(3'b001, 1'b0, 2'd3, 3'b000);
        check("R4 edge2", 32'(host_rdata), 32'd0);
        step(3'b001, 1'b0, 2'd3, 3'b000);
        check("R4 edge3", 32'(host_rdata), 32'd1);
        check("R7 wake_a low", 32'(wake_a_n), 32'd0);
        check("R8 wake_b high", 32'(wake_b_n), 32'd1);
        // R5: write 0 keeps, write 1 clears
        step(3'b001, 1'b1, 2'd3, 3'b110);
        read_reg(2'd3, 3'b001, "R5 write0 keeps");
        step(3'b001, 1'b1, 2'd3, 3'b001);
        read_reg(2'd3, 3'b000, "R5 write1 clears");
        // R2: falling with polarity 0 ignored
        step(3'b000, 1'b0, 2'd3, 3'b000);
        repeat (4) step(3'b000, 1'b0, 2'd3, 3'b000);
        check("R2 falling ignored", 32'(host_rdata), 32'd0);

        // R3: polarity 1 on pin 1
        step(3'b000, 1'b1, 2'd0, 3'b010);
        step(3'b010, 1'b0, 2'd3, 3'b000);
        repeat (4) step(3'b010, 1'b0, 2'd3, 3'b000);
        check("R3 rising ignored", 32'(host_rdata), 32'd0);
        step(3'b000, 1'b0, 2'd3, 3'b000);
        repeat (3) step(3'b000, 1'b0, 2'd3, 3'b000);
        check("R3 falling sets, R11 only pin 1", 32'(host_rdata), 32'b010);
        check("R7 wake_a from pin1", 32'(wake_a_n), 32'd0);
        // R8: route B only, A off
        step(3'b000, 1'b1, 2'd1, 3'b000);
        step(3'b000, 1'b1, 2'd2, 3'b010);
        check("R8 wake_b low", 32'(wake_b_n), 32'd0);
        check("R7 wake_a high", 32'(wake_a_n), 32'd1);
        step(3'b000, 1'b1, 2'd3, 3'b111);

        // R6: pin 2 rising, clear at the setting edge
        step(3'b100, 1'b0, 2'd3, 3'b000);
        step(3'b100, 1'b0, 2'd3, 3'b000);
        step(3'b100, 1'b1, 2'd3, 3'b100);
        read_reg(2'd3, 3'b100, "R6 set wins");
        // R9: write to polarity leaves routing
        step(3'b100, 1'b1, 2'd0, 3'b101);
        read_reg(2'd2, 3'b010, "R9 route B kept");
        read_reg(2'd0, 3'b101, "R9 polarity written");
        step(3'b100, 1'b1, 2'd3, 3'b111);
        step(3'b100, 1'b1, 2'd3, 3'b011);
        read_reg(2'd3, 3'b000, "R9 status write no set");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] p;
            p = cur_p;
            if ($urandom_range(0, 3) == 0) p = p ^ 3'($urandom_range(0, 7));
            step(p, ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)));
        end
        finish_run();
    end
endmodule